// File: doc/BRIEF.md
# Memory Test Mismatch Error Logger

This block sits beside the data comparator of a memory traffic generator. On every cycle where the generator presents a compare, it XORs the read word with the expected word. It then keeps the error status that a debug console reads. The status has two parts. The first is a snapshot of the first failing compare: its address, its mismatch pattern and its expected word. The second is a per-bit sticky accumulation of every mismatching bit seen since the last full clear. The block also raises a one-cycle strobe for each mismatching compare, which can arm an external logic analyzer.

Two clear pulses reset the status. The light clear drops the first-error snapshot and the error flag but keeps the sticky bits. The full clear drops everything. Both are honoured only while the generator reports its error-done or pause state, so an operator cannot wipe the record while traffic runs. After any honoured clear, the next mismatch is taken as a new first error.

Top module: `mem_err_logger`

## Requirements
- R1: A compare is evaluated only in a cycle with `cmp_valid` high, and its mismatch vector is `rd_data` XOR `exp_data`. A compare with `cmp_valid` low, or with equal words, changes no status output.
- R2: The first mismatching compare after reset or after an honoured clear has a visible effect one cycle later: `err_seen` is 1, `first_addr` holds its address and `first_bits` holds its mismatch vector.
- R3: `first_exp` holds the expected word of that same first mismatching compare.
- R4: While `err_seen` is 1 and no clear is honoured, later mismatches leave `first_addr`, `first_bits` and `first_exp` unchanged.
- R5: Once set, `err_seen` stays 1 until a clear is honoured.
- R6: One cycle after each compare, `sticky_bits` equals its previous value OR that compare's mismatch vector, unless a full clear is honoured.
- R7: `mm_strobe` is 1 exactly in the cycle after a compare with a non-zero mismatch vector, and 0 in every other cycle.
- R8: An honoured `clr_pulse` sets `err_seen`, `first_addr`, `first_bits` and `first_exp` to zero in the next cycle and leaves `sticky_bits` unchanged.
- R9: An honoured `clr_all_pulse` also sets `sticky_bits` to zero. When both pulses arrive together, the full clear applies.
- R10: A clear is honoured only when `gen_state` equals parameter `ERRDONE_CODE` or `PAUSE_CODE`. In any other state both pulses are ignored.
- R11: A mismatch in the same cycle as an honoured clear is recorded after the clear. It becomes the new first error, and its bits enter `sticky_bits`.
- R12: While `rst_n` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cmp_valid | input | 1 | Compare strobe for the current cycle |
| cmp_addr | input | ADDR_W | Address of the compared read |
| rd_data | input | DATA_W | Data returned by memory |
| exp_data | input | DATA_W | Data the generator expected |
| gen_state | input | STATE_W | Current state code of the traffic generator |
| clr_pulse | input | 1 | Clear status, keep sticky bits |
| clr_all_pulse | input | 1 | Clear all status including sticky bits |
| err_seen | output | 1 | At least one mismatch since the last clear |
| first_addr | output | ADDR_W | Address of the first mismatch |
| first_bits | output | DATA_W | Mismatch vector of the first mismatch |
| first_exp | output | DATA_W | Expected word of the first mismatch |
| sticky_bits | output | DATA_W | OR of all mismatch vectors since the last full clear |
| mm_strobe | output | 1 | One-cycle pulse after each mismatching compare |

## Verification
The bench builds the logger with a 16-bit data word, a 12-bit address and a 3-bit state code, with error-done at 5 and pause at 1. With the narrow word, random bit flips fill and then refill every sticky bit within a few hundred compares. With eight state codes, a quarter of the random clear pulses land in an honouring state. Clear pulses that coincide with mismatches, and clears issued in refusing states, therefore occur many times in one run, together with the directed cases for simultaneous pulses.

// File: rtl/mel_pkg.sv
package mel_pkg;

  typedef enum logic [1:0] {
    CLR_NONE = 2'd0,
    CLR_KEEP = 2'd1,
    CLR_ALL  = 2'd2
  } clr_cmd_e;

  function automatic clr_cmd_e decode_clear(input logic state_ok,
                                            input logic light,
                                            input logic full);
    if (!state_ok)  return CLR_NONE;
    else if (full)  return CLR_ALL;
    else if (light) return CLR_KEEP;
    else            return CLR_NONE;
  endfunction

endpackage

// File: rtl/mel_clear_gate.sv
module mel_clear_gate
  import mel_pkg::*;
#(
  parameter int unsigned STATE_W = 4,
  parameter logic [STATE_W-1:0] ERRDONE_CODE = 7,
  parameter logic [STATE_W-1:0] PAUSE_CODE   = 2
)(
  input  logic [STATE_W-1:0] gen_state,
  input  logic               clr_pulse,
  input  logic               clr_all_pulse,
  output clr_cmd_e           clr_cmd
);

  logic state_ok;

  always_comb begin
    state_ok = (gen_state == ERRDONE_CODE) || (gen_state == PAUSE_CODE);
    clr_cmd  = decode_clear(state_ok, clr_pulse, clr_all_pulse);
  end

endmodule

// File: rtl/mel_compare.sv
module mel_compare #(
  parameter int unsigned DATA_W = 64
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_valid,
  input  logic [DATA_W-1:0] rd_data,
  input  logic [DATA_W-1:0] exp_data,
  output logic [DATA_W-1:0] mm_vec,
  output logic              mm_hit,
  output logic              strobe_q
);

  logic strobe_d;

  always_comb begin
    mm_vec   = cmp_valid ? (rd_data ^ exp_data) : '0;
    mm_hit   = |mm_vec;
    strobe_d = mm_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= 1'b0;
    else        strobe_q <= strobe_d;
  end

  assert_strobe_on_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && (rd_data != exp_data)) |=> strobe_q);

  assert_strobe_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmp_valid || (rd_data == exp_data)) |=> !strobe_q);

endmodule

// File: rtl/mel_first_capture.sv
module mel_first_capture
  import mel_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 64
)(
  input  logic              clk,
  input  logic              rst_n,
  input  clr_cmd_e          clr_cmd,
  input  logic              mm_hit,
  input  logic [ADDR_W-1:0] cmp_addr,
  input  logic [DATA_W-1:0] mm_vec,
  input  logic [DATA_W-1:0] exp_data,
  output logic              seen_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] bits_q,
  output logic [DATA_W-1:0] exp_q
);

  logic              seen_d;
  logic [ADDR_W-1:0] addr_d;
  logic [DATA_W-1:0] bits_d;
  logic [DATA_W-1:0] exp_d;
  logic              load_en;

  always_comb begin
    seen_d = seen_q;
    addr_d = addr_q;
    bits_d = bits_q;
    exp_d  = exp_q;
    if (clr_cmd != CLR_NONE) begin
      seen_d = 1'b0;
      addr_d = '0;
      bits_d = '0;
      exp_d  = '0;
    end
    if (mm_hit && !seen_d) begin
      seen_d = 1'b1;
      addr_d = cmp_addr;
      bits_d = mm_vec;
      exp_d  = exp_data;
    end
    load_en = (clr_cmd != CLR_NONE) || (mm_hit && !seen_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      addr_q <= '0;
      bits_q <= '0;
      exp_q  <= '0;
    end else if (load_en) begin
      seen_q <= seen_d;
      addr_q <= addr_d;
      bits_q <= bits_d;
      exp_q  <= exp_d;
    end
  end

  assert_capture_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mm_hit && !seen_q) |=> (seen_q && addr_q == $past(cmp_addr) && bits_q == $past(mm_vec)));

  assert_capture_exp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mm_hit && !seen_q) |=> (exp_q == $past(exp_data)));

  assert_hold_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && clr_cmd == CLR_NONE) |=> ($stable(addr_q) && $stable(bits_q) && $stable(exp_q)));

  assert_flag_sticks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && clr_cmd == CLR_NONE) |=> seen_q);

  assert_clear_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_cmd != CLR_NONE && !mm_hit) |=> (!seen_q && addr_q == '0 && bits_q == '0 && exp_q == '0));

  assert_clear_relatch_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_cmd != CLR_NONE && mm_hit) |=> (seen_q && bits_q == $past(mm_vec) && addr_q == $past(cmp_addr)));

endmodule

// File: rtl/mel_sticky.sv
module mel_sticky
  import mel_pkg::*;
#(
  parameter int unsigned DATA_W = 64
)(
  input  logic              clk,
  input  logic              rst_n,
  input  clr_cmd_e          clr_cmd,
  input  logic              mm_hit,
  input  logic [DATA_W-1:0] mm_vec,
  output logic [DATA_W-1:0] sticky_q
);

  logic [DATA_W-1:0] sticky_d;
  logic              full_clr;
  logic              load_en;

  always_comb begin
    full_clr = (clr_cmd == CLR_ALL);
    sticky_d = (full_clr ? '0 : sticky_q) | mm_vec;
    load_en  = full_clr || mm_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sticky_q <= '0;
    else if (load_en) sticky_q <= sticky_d;
  end

  assert_accumulate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_cmd != CLR_ALL) |=> ((sticky_q & ($past(sticky_q) | $past(mm_vec))) == sticky_q
                              && (sticky_q & $past(sticky_q)) == $past(sticky_q)
                              && (sticky_q & $past(mm_vec)) == $past(mm_vec)));

  assert_full_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_cmd == CLR_ALL) |=> (sticky_q == $past(mm_vec)));

endmodule

// File: rtl/mem_err_logger.sv
module mem_err_logger
  import mel_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned DATA_W  = 64,
  parameter int unsigned STATE_W = 4,
  parameter logic [STATE_W-1:0] ERRDONE_CODE = 7,
  parameter logic [STATE_W-1:0] PAUSE_CODE   = 2
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmp_valid,
  input  logic [ADDR_W-1:0]  cmp_addr,
  input  logic [DATA_W-1:0]  rd_data,
  input  logic [DATA_W-1:0]  exp_data,
  input  logic [STATE_W-1:0] gen_state,
  input  logic               clr_pulse,
  input  logic               clr_all_pulse,
  output logic               err_seen,
  output logic [ADDR_W-1:0]  first_addr,
  output logic [DATA_W-1:0]  first_bits,
  output logic [DATA_W-1:0]  first_exp,
  output logic [DATA_W-1:0]  sticky_bits,
  output logic               mm_strobe
);

  clr_cmd_e          clr_cmd;
  logic [DATA_W-1:0] mm_vec;
  logic              mm_hit;

  mel_clear_gate #(
    .STATE_W(STATE_W), .ERRDONE_CODE(ERRDONE_CODE), .PAUSE_CODE(PAUSE_CODE)
  ) u_gate (
    .gen_state(gen_state), .clr_pulse(clr_pulse),
    .clr_all_pulse(clr_all_pulse), .clr_cmd(clr_cmd)
  );

  mel_compare #(.DATA_W(DATA_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .rd_data(rd_data),
    .exp_data(exp_data), .mm_vec(mm_vec), .mm_hit(mm_hit), .strobe_q(mm_strobe)
  );

  mel_first_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_first (
    .clk(clk), .rst_n(rst_n), .clr_cmd(clr_cmd), .mm_hit(mm_hit),
    .cmp_addr(cmp_addr), .mm_vec(mm_vec), .exp_data(exp_data),
    .seen_q(err_seen), .addr_q(first_addr), .bits_q(first_bits), .exp_q(first_exp)
  );

  mel_sticky #(.DATA_W(DATA_W)) u_sticky (
    .clk(clk), .rst_n(rst_n), .clr_cmd(clr_cmd), .mm_hit(mm_hit),
    .mm_vec(mm_vec), .sticky_q(sticky_bits)
  );

  assert_refused_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_seen && gen_state != ERRDONE_CODE && gen_state != PAUSE_CODE)
      |=> (err_seen && $stable(first_addr) && $stable(first_bits)));

  assert_idle_compare_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmp_valid && !clr_pulse && !clr_all_pulse)
      |=> ($stable(sticky_bits) && $stable(err_seen) && !mm_strobe));

  assert_reset_zero_R12: assert property (@(posedge clk)
    !rst_n |-> (!err_seen && sticky_bits == '0 && !mm_strobe));

endmodule

// File: tb/mem_err_logger_test.sv
module mem_err_logger_test;

  localparam int unsigned AW = 12;
  localparam int unsigned DW = 16;
  localparam int unsigned SW = 3;
  localparam logic [SW-1:0] ST_DONE  = 3'd5;
  localparam logic [SW-1:0] ST_PAUSE = 3'd1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cmp_valid;
  logic [AW-1:0] cmp_addr;
  logic [DW-1:0] rd_data, exp_data;
  logic [SW-1:0] gen_state;
  logic          clr_pulse, clr_all_pulse;
  logic          err_seen, mm_strobe;
  logic [AW-1:0] first_addr;
  logic [DW-1:0] first_bits, first_exp, sticky_bits;

  int checks = 0;
  int errors = 0;

  logic          m_seen, m_strobe;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_bits, m_exp, m_sticky;

  always #5 clk = ~clk;

  mem_err_logger #(
    .ADDR_W(AW), .DATA_W(DW), .STATE_W(SW),
    .ERRDONE_CODE(ST_DONE), .PAUSE_CODE(ST_PAUSE)
  ) uut (
    .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_addr(cmp_addr),
    .rd_data(rd_data), .exp_data(exp_data), .gen_state(gen_state),
    .clr_pulse(clr_pulse), .clr_all_pulse(clr_all_pulse),
    .err_seen(err_seen), .first_addr(first_addr), .first_bits(first_bits),
    .first_exp(first_exp), .sticky_bits(sticky_bits), .mm_strobe(mm_strobe)
  );

  function automatic logic [DW-1:0] f_mismatch(input logic v, input logic [DW-1:0] r,
                                                input logic [DW-1:0] e);
    return v ? (r ^ e) : '0;
  endfunction

  function automatic logic f_honoured(input logic [SW-1:0] st);
    return (st == ST_DONE) || (st == ST_PAUSE);
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_step();
    logic [DW-1:0] mv;
    logic ok;
    mv = f_mismatch(cmp_valid, rd_data, exp_data);
    ok = f_honoured(gen_state);
    if (ok && (clr_pulse || clr_all_pulse)) begin
      m_seen = 1'b0; m_addr = '0; m_bits = '0; m_exp = '0;
      if (clr_all_pulse) m_sticky = '0;
    end
    if ((mv != '0) && !m_seen) begin
      m_seen = 1'b1; m_addr = cmp_addr; m_bits = mv; m_exp = exp_data;
    end
    m_sticky = m_sticky | mv;
    m_strobe = (mv != '0);
  endtask

  task automatic compare_all(input string tag);
    check({tag, " err_seen R5"},     64'(err_seen),    64'(m_seen));
    check({tag, " first_addr R2"},   64'(first_addr),  64'(m_addr));
    check({tag, " first_bits R4"},   64'(first_bits),  64'(m_bits));
    check({tag, " first_exp R3"},    64'(first_exp),   64'(m_exp));
    check({tag, " sticky_bits R6"},  64'(sticky_bits), 64'(m_sticky));
    check({tag, " mm_strobe R7"},    64'(mm_strobe),   64'(m_strobe));
  endtask

  task automatic cycle(input logic v, input logic [AW-1:0] a, input logic [DW-1:0] r,
                       input logic [DW-1:0] e, input logic [SW-1:0] st,
                       input logic c, input logic ca, input string tag);
    @(negedge clk);
    cmp_valid = v; cmp_addr = a; rd_data = r; exp_data = e;
    gen_state = st; clr_pulse = c; clr_all_pulse = ca;
    @(posedge clk);
    model_step();
    #1;
    compare_all(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R12 actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; cmp_valid = 0; cmp_addr = '0; rd_data = '0; exp_data = '0;
    gen_state = '0; clr_pulse = 0; clr_all_pulse = 0;
    m_seen = 0; m_addr = '0; m_bits = '0; m_exp = '0; m_sticky = '0; m_strobe = 0;
    repeat (3) @(posedge clk);
    #1;
    compare_all("reset R12");
    @(negedge clk);
    rst_n = 1'b1;

    // R1: invalid compare with differing words, then equal words
    cycle(1'b0, 12'h111, 16'hFFFF, 16'h0000, 3'd0, 0, 0, "invalid R1");
    cycle(1'b1, 12'h112, 16'hA5A5, 16'hA5A5, 3'd0, 0, 0, "equal R1");
    // R2/R3: first error
    cycle(1'b1, 12'h2AB, 16'h00F1, 16'h00F0, 3'd0, 0, 0, "first R2");
    // R4: second error keeps snapshot
    cycle(1'b1, 12'h3CD, 16'h8000, 16'h0000, 3'd0, 0, 0, "second R4");
    // R10: clears in refusing state
    cycle(1'b0, 12'h0, 16'h0, 16'h0, 3'd4, 1, 1, "refused R10");
    // R8: light clear in error-done
    cycle(1'b0, 12'h0, 16'h0, 16'h0, ST_DONE, 1, 0, "light clear R8");
    // R11: mismatch together with honoured clear
    cycle(1'b1, 12'h455, 16'h0300, 16'h0000, ST_PAUSE, 1, 0, "relatch R11");
    // R9: both pulses in pause -> full clear
    cycle(1'b0, 12'h0, 16'h0, 16'h0, ST_PAUSE, 1, 1, "full clear R9");
    cycle(1'b1, 12'h566, 16'h1234, 16'h1230, ST_DONE, 0, 1, "full relatch R9");

    for (int i = 0; i < 3000; i++) begin
      logic v, c, ca;
      logic [DW-1:0] e, r;
      v  = ($urandom % 2) == 0;
      e  = DW'($urandom);
      r  = (($urandom % 2) == 0) ? e : (e ^ DW'(1 << ($urandom % DW)) ^ (DW'($urandom) & DW'($urandom) & DW'($urandom)));
      c  = ($urandom % 20) == 0;
      ca = ($urandom % 40) == 0;
      cycle(v, AW'($urandom), r, e, SW'($urandom), c, ca, "random R10");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule